// File: doc/BRIEF.md
# Slot Power Sequencer

This block switches six supply-enable lines on and off in a configured order. Each line belongs to one of six ordered slots. Power-up runs from the lowest slot to the highest. A slot's lines are released once that slot's programmable delay has run out. The next slot's delay starts only after every supply in the current slot reports power-good. All delays are counted on a time base derived from a clock-enable prescaler (one tick is 80 µs at the default setting).

Power-up starts when a hardware enable and a software enable are both true. When the last slot has passed, the block raises a done flag, which marks entry into the monitoring phase. Power-down begins when either enable is dropped, when a fault shutdown is requested, or when a power-good timeout expires during power-up. A configuration bit selects the power-down mode: either every line drops at once, or the slots drop one by one in descending order, each after its own delay. A 4-bit state code shows where the sequence stands.

Top module: `pwr_slot_seq`

## Requirements
- R1: After reset, en_out is 0, seq_state is 0, seq_done is 0 and seq_fault is 0.
- R2: The block leaves the idle state (code 0) for the delay state (code 1) of slot 1 on the first clock edge at which hw_en and sw_en are both 1, fault_req is 0 and seq_fault is 0. In any other case it stays idle.
- R3: Channel i takes its slot from slot_map[3i+2:3i]. Values 1 to 6 name a slot; 0 and 7 mean the channel is never enabled. All channels of one slot rise on the same clock edge, and slots rise in ascending order.
- R4: The delay code of slot s is dly_code[4(s-1)+3:4(s-1)]. The slot's lines rise exactly 2^code × TICK_DIV cycles after the block enters the delay state for that slot.
- R5: After a slot's lines rise, the block waits in state 2. It moves on at the first edge at which the power-good bits of all channels in that slot are 1. Until then, no line of a later slot rises.
- R6: A slot with no channels assigned leaves state 2 one cycle after its delay ends, whatever pgood shows.
- R7: After slot 6 passes, seq_state is 3 and seq_done is 1. While seq_done is 1, every channel with a slot value of 1 to 6 is enabled.
- R8: State codes are 0 idle, 1 slot delay, 2 power-good wait, 3 monitoring, 4 reverse power-down.
- R9: In states 1 to 3, dropping either enable or raising fault_req starts power-down. With rev_down = 0, all lines are 0 and the state is 0 on the next edge.
- R10: With rev_down = 1, power-down enters state 4 at the current slot (slot 6 when coming from monitoring). At each slot it waits that slot's delay, then clears that slot's lines, and continues downward to slot 1 before returning to idle. Enable changes have no effect during state 4, and no line rises in that state.
- R11: If state 2 lasts PG_TO ticks without the slot's power-good being complete, seq_fault is set and power-down starts in the configured mode. fault_req also sets seq_fault.
- R12: While seq_fault is 1, power-up does not start. seq_fault clears in the idle state on an edge where an enable is low and fault_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| rev_down | input | 1 | Power-down mode: 1 reverse slot order, 0 all at once |
| slot_map | input | NCH*3 | Slot number per channel, 3 bits each |
| dly_code | input | NSLOT*4 | Delay code per slot, 4 bits each |
| pgood | input | NCH | Power-good per channel |
| fault_req | input | 1 | Fault shutdown request |
| en_out | output | NCH | Supply enable lines |
| seq_done | output | 1 | Power-up complete, monitoring phase |
| seq_fault | output | 1 | Sequencing fault latched |
| seq_state | output | 4 | Sequencer state code |

## Verification
The slot map used places two channels in one slot, leaves two slots empty and leaves one channel unassigned. This separates simultaneous release, skipping of empty slots and exclusion of unassigned channels. Power-good is either echoed from the enables with a lag or held back on chosen channels. This tells a slot that is gated by its supplies apart from one that times out, and a delayed release apart from a fault. Shutdowns are triggered from monitoring and from mid-sequence, by each enable and by fault request, in both power-down modes. The reverse runs also toggle an enable back on mid-descent to show that it is ignored.

// File: rtl/pwr_slot_seq.sv
module pwr_slot_seq #(
  parameter int NCH      = 6,
  parameter int NSLOT    = 6,
  parameter int SW       = 3,
  parameter int CW       = 4,
  parameter int TICK_DIV = 16000,
  parameter int PG_TO    = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              sw_en,
  input  logic              rev_down,
  input  logic [NCH*SW-1:0] slot_map,
  input  logic [NSLOT*CW-1:0] dly_code,
  input  logic [NCH-1:0]    pgood,
  input  logic              fault_req,
  output logic [NCH-1:0]    en_out,
  output logic              seq_done,
  output logic              seq_fault,
  output logic [3:0]        seq_state
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TW = 17;

  typedef enum logic [3:0] {S_IDLE = 4'd0, S_UPD = 4'd1, S_UPG = 4'd2, S_MON = 4'd3, S_DND = 4'd4} st_t;

  st_t st, nst;
  logic [SW-1:0] slot, nslot;
  logic [NCH-1:0] nen, smask;
  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;
  logic fset;

  wire req  = hw_en & sw_en;
  wire tick = (pre == PW'(TICK_DIV - 1));

  for (genvar i = 0; i < NCH; i++) begin : g_mask
    assign smask[i] = (slot_map[i*SW +: SW] == slot);
  end

  wire [CW-1:0] code    = dly_code[(int'(slot) - 1)*CW +: CW];
  wire [TW-1:0] dly_lim = (TW'(1) << code) - TW'(1);
  wire dly_end = tick && (tcnt == dly_lim);
  wire pg_ok   = &(pgood | ~smask);
  wire pg_to   = (st == S_UPG) && !pg_ok && tick && (tcnt == TW'(PG_TO - 1));
  wire abort   = !req || fault_req || pg_to;
  wire restart = (nst != st) || (nslot != slot);

  always_comb begin
    nst   = st;
    nslot = slot;
    nen   = en_out;
    fset  = fault_req | pg_to;
    case (st)
      S_IDLE: if (req && !seq_fault && !fault_req) begin
        nst   = S_UPD;
        nslot = SW'(1);
      end
      S_UPD, S_UPG, S_MON: begin
        if (abort) begin
          if (rev_down) nst = S_DND;
          else begin
            nst = S_IDLE;
            nen = '0;
          end
        end else if (st == S_UPD) begin
          if (dly_end) begin
            nst = S_UPG;
            nen = en_out | smask;
          end
        end else if (st == S_UPG && pg_ok) begin
          if (slot == SW'(NSLOT)) nst = S_MON;
          else begin
            nst   = S_UPD;
            nslot = slot + SW'(1);
          end
        end
      end
      S_DND: if (dly_end) begin
        nen = en_out & ~smask;
        if (slot == SW'(1)) nst = S_IDLE;
        else nslot = slot - SW'(1);
      end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slot      <= SW'(1);
      en_out    <= '0;
      seq_fault <= 1'b0;
      pre       <= '0;
      tcnt      <= '0;
    end else begin
      st        <= nst;
      slot      <= nslot;
      en_out    <= nen;
      seq_fault <= fset | (seq_fault & !(st == S_IDLE && !req));
      if (restart) begin
        pre  <= '0;
        tcnt <= '0;
      end else if (tick) begin
        pre  <= '0;
        tcnt <= tcnt + TW'(1);
      end else begin
        pre  <= pre + PW'(1);
      end
    end
  end

  assign seq_done  = (st == S_MON);
  assign seq_state = st;
endmodule

module pwr_slot_seq_chk #(
  parameter int NCH = 6,
  parameter int SW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_en,
  input logic              sw_en,
  input logic              rev_down,
  input logic              fault_req,
  input logic [NCH*SW-1:0] slot_map,
  input logic [NCH-1:0]    en_out,
  input logic              seq_done,
  input logic              seq_fault,
  input logic [3:0]        seq_state
);
  logic [NCH-1:0] mapped;
  for (genvar i = 0; i < NCH; i++) begin : g_map
    assign mapped[i] = (slot_map[i*SW +: SW] != '0) && (slot_map[i*SW +: SW] != '1);
  end

  a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd0) && (!(hw_en && sw_en) || fault_req) |=> seq_state == 4'd0);

  a_r3_up_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd1) && hw_en && sw_en && !fault_req |=> (en_out & $past(en_out)) == $past(en_out));

  a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (en_out & mapped) == mapped);

  a_r9_simul_off: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state inside {4'd1, 4'd2, 4'd3}) && !rev_down && !(hw_en && sw_en) |=> (en_out == '0) && (seq_state == 4'd0));

  a_r10_rev_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 4'd4 |=> $countones(en_out) <= $countones($past(en_out)));

  a_r12_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fault && (seq_state == 4'd0) |=> seq_state == 4'd0);
endmodule

bind pwr_slot_seq pwr_slot_seq_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .rev_down(rev_down),
  .fault_req(fault_req), .slot_map(slot_map), .en_out(en_out), .seq_done(seq_done),
  .seq_fault(seq_fault), .seq_state(seq_state));

// File: tb/tb_pwr_slot_seq.sv
module tb_pwr_slot_seq;
  localparam int TD = 3, PGT = 5;
  logic clk = 0, rst_n = 0, hw_en = 0, sw_en = 0, rev_down = 0, fault_req = 0;
  logic [17:0] slot_map = 18'b000_110_100_011_001_001;
  logic [23:0] dly_code = 24'h010201;
  logic [5:0] pgood = 0, allow = 6'h3f, en_out;
  logic seq_done, seq_fault;
  logic [3:0] seq_state;
  int checks = 0, bad = 0, cyc = 0;

  pwr_slot_seq #(.TICK_DIV(TD), .PG_TO(PGT)) dut (.*);

  always #2.5 clk = ~clk;

  int m_ph, m_slot, m_left;
  bit [5:0] m_en;
  bit m_flt;

  function automatic bit [5:0] smask(int s);
    bit [5:0] m = 0;
    for (int i = 0; i < 6; i++) if (int'(slot_map[3*i +: 3]) == s) m[i] = 1;
    return m;
  endfunction
  function automatic int dly(int s);
    return (1 << dly_code[4*(s-1) +: 4]) * TD;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_slot = 1; m_left = 0; m_en = 0; m_flt = 0;
    end else begin
      bit req, pgok, nf, tmo;
      bit [5:0] mk;
      req = hw_en && sw_en;
      mk = smask(m_slot);
      pgok = ((pgood & mk) == mk);
      nf = m_flt || fault_req;
      if (m_ph == 0 && !req && !fault_req) nf = 0;
      if (m_ph == 1 || m_ph == 2 || m_ph == 4) m_left--;
      tmo = (m_ph == 2) && !pgok && (m_left == 0);
      case (m_ph)
        0: if (req && !m_flt && !fault_req) begin m_ph = 1; m_slot = 1; m_left = dly(1); end
        1, 2, 3: begin
          if (!req || fault_req || tmo) begin
            if (tmo) nf = 1;
            if (rev_down) begin m_ph = 4; m_left = dly(m_slot); end
            else begin m_ph = 0; m_en = 0; end
          end else if (m_ph == 1) begin
            if (m_left == 0) begin m_en |= mk; m_ph = 2; m_left = PGT * TD; end
          end else if (m_ph == 2 && pgok) begin
            if (m_slot == 6) m_ph = 3;
            else begin m_slot++; m_ph = 1; m_left = dly(m_slot); end
          end
        end
        4: if (m_left == 0) begin
          m_en &= ~mk;
          if (m_slot == 1) m_ph = 0;
          else begin m_slot--; m_left = dly(m_slot); end
        end
        default: ;
      endcase
      m_flt = nf;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  bit track = 0;
  always @(negedge clk) begin
    cyc++;
    pgood <= en_out & allow;
    if (track) begin
      chk("R3 en_out", en_out, m_en);
      chk("R8 state", seq_state, m_ph);
      chk("R7 done", seq_done, m_ph == 3);
      chk("R11 fault", seq_fault, m_flt);
    end
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic cyc_n(int n); repeat (n) @(negedge clk); endtask
  task automatic wait_st(int v);
    for (int i = 0; i < 500 && seq_state != 4'(v); i++) @(negedge clk);
  endtask

  initial begin
    cyc_n(2);
    chk("R1 en", en_out, 0); chk("R1 state", seq_state, 0);
    chk("R1 done", seq_done, 0); chk("R1 fault", seq_fault, 0);
    rst_n = 1; track = 1;
    hw_en = 1; cyc_n(20);
    chk("R2 one enable only", seq_state, 0);
    sw_en = 1; @(negedge clk);
    chk("R2 start", seq_state, 1);
    begin
      int n = 0;
      while (en_out == 0 && n < 100) begin @(negedge clk); n++; end
      chk("R4 slot1 delay", n, 2 * TD);
      chk("R3 same slot", en_out, 6'b000011);
    end
    wait_st(3);
    chk("R7 all mapped on", en_out, 6'b011111);
    chk("R6 empty slots passed", seq_done, 1);
    sw_en = 0; @(negedge clk);
    chk("R9 simul off", en_out, 0);
    cyc_n(3);
    allow = 6'b111011; sw_en = 1;
    wait_st(2); wait_st(1); wait_st(2); wait_st(1); wait_st(2);
    cyc_n(8);
    chk("R5 held in pg wait", seq_state, 2);
    chk("R5 slot4 not yet", en_out[3], 0);
    allow = 6'h3f; wait_st(3);
    hw_en = 0; cyc_n(3); hw_en = 1; cyc_n(2);
    allow = 6'b110111; rev_down = 1;
    wait_st(4);
    chk("R11 timeout fault", seq_fault, 1);
    wait_st(0); cyc_n(10);
    chk("R12 blocked", seq_state, 0);
    chk("R10 all off after reverse", en_out, 0);
    hw_en = 0; @(negedge clk);
    chk("R12 cleared", seq_fault, 0);
    allow = 6'h3f; hw_en = 1; wait_st(3);
    sw_en = 0; cyc_n(2); sw_en = 1;
    while (en_out[4]) @(negedge clk);
    chk("R10 slot6 before slot1", en_out[0], 1);
    wait_st(0); cyc_n(2);
    rev_down = 0; wait_st(3);
    fault_req = 1; @(negedge clk); fault_req = 0;
    chk("R9 fault off", en_out, 0);
    chk("R11 fault req", seq_fault, 1);
    cyc_n(5);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule